// File: doc/BRIEF.md
# SD Card Host DMA Engine

This block moves data between the data path of an SD/MMC card controller and system memory, one contiguous buffer per transfer. Software programs a mode word, a 128-byte-aligned buffer address and a beat count through a 32-bit register port. It then writes the start bit. The engine either reads words from memory and hands them to the card transmit stream, or takes words from the card receive stream and writes them to memory. Each memory access is a single handshaked request.

Two fixed-direction channels exist: channel 0 feeds the card for write commands and channel 1 drains the card for read commands. A mode bit selects the channel. Completion and failure are recorded in two status registers, one for end events and one for errors, each with a mask register. A single interrupt line is the OR of all unmasked status bits. Each channel has its own active-low soft reset bit.

Top module: `sd_dma_engine`

## Requirements
- R1: After reset the end status register (0x840) and the error status register (0x850) read 0. Both mask registers (0x848, 0x858) read 0xFFFFFFFF, the channel reset register (0x830) reads 0x300, the mode register (0x820) reads 0, irq_o is low and no memory request is made.
- R2: With mode bit 16 = 0 (channel 0), a start reads the programmed number of 32-bit words from memory and presents them on the card transmit stream in address order. It then sets bit 16 of the end status register.
- R3: With mode bit 16 = 1 (channel 1), a start takes the programmed number of words from the card receive stream and writes them to memory in arrival order. It then sets bit 20 of the end status register.
- R4: Mode bit 0 = 1 advances the memory address by 4 bytes after every beat. Mode bit 0 = 0 uses the start address for every beat.
- R5: Writing 1 to bit 0 of the control register (0x828) starts a transfer using the current mode, address (0x880) and beat count (0x888) registers. A start written while a transfer is active is ignored.
- R6: A start with a buffer address whose low 7 bits are not all zero makes no memory request and sets no end bit. It sets the channel's error bit instead: bit 16 of 0x850 for channel 0, bit 17 for channel 1.
- R7: A memory response flagged as an error sets the active channel's error bit and ends the transfer at once. No further memory request is made and the end bit stays clear.
- R8: Writing 0 to a status bit clears it. Writing 1 to a status bit leaves it unchanged.
- R9: irq_o is high exactly when some status bit is set and its mask bit is 0. A mask bit of 1 suppresses that bit.
- R10: While bit 8 (channel 0) or bit 9 (channel 1) of the reset register is 0, that channel's active transfer is dropped, its end and error bits are held clear and starts on it are ignored. Writing the bit back to 1 releases the channel.
- R11: A start with a beat count of 0 sets the channel's end bit without any memory or card activity.
- R12: A memory request holds its address, direction and write data until acknowledged. A card transmit word holds valid and data until the card accepts it.
- R13: The mode register stores bit 16, the bus-width field in bits 5:4 and bit 0, and reads back those bits with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | OR of unmasked status bits |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |
| mem_err_i | input | 1 | Error flag qualifying mem_ack_i |
| mem_rdata_i | input | 32 | Memory read data qualifying mem_ack_i |
| card_tx_valid_o | output | 1 | Word available for the card |
| card_tx_data_o | output | 32 | Word to the card |
| card_tx_ready_i | input | 1 | Card accepts the word |
| card_rx_valid_i | input | 1 | Word available from the card |
| card_rx_data_i | input | 32 | Word from the card |
| card_rx_ready_o | output | 1 | Engine accepts the card word |

## Verification
The bench stalls the card transmit side and, during the stall, rewrites the address register and issues a second start. An engine that restarted on that second start would produce requests at the new address, which the memory model rejects as unexpected. It injects a memory error mid-transfer. An engine that did not stop would keep issuing requests or set the end bit. It pulls a channel's reset bit low during a stalled transfer. A design that ignored the bit would keep the transmit word valid and leave stale error status. Unaligned and zero-length starts are checked for silent memory traffic. Write-one and write-zero status writes are checked for the wrong polarity of clearing.

// File: rtl/sd_dma_pkg.sv
package sd_dma_pkg;
  localparam int REG_AW = 12;
  localparam int REG_W  = 32;
  localparam int NUM_CH = 2;

  localparam logic [REG_AW-1:0] OFF_MODE  = 12'h820;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h828;
  localparam logic [REG_AW-1:0] OFF_CHRST = 12'h830;
  localparam logic [REG_AW-1:0] OFF_STAT1 = 12'h840;
  localparam logic [REG_AW-1:0] OFF_MASK1 = 12'h848;
  localparam logic [REG_AW-1:0] OFF_STAT2 = 12'h850;
  localparam logic [REG_AW-1:0] OFF_MASK2 = 12'h858;
  localparam logic [REG_AW-1:0] OFF_BUF   = 12'h880;
  localparam logic [REG_AW-1:0] OFF_LEN   = 12'h888;

  localparam int MODE_CH_BIT  = 16;
  localparam int MODE_INC_BIT = 0;
  localparam int CHRST_LSB    = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_MEM_RD, ST_CARD_OUT, ST_CARD_IN, ST_MEM_WR
  } xfer_state_e;

  function automatic int end_pos(int ch);
    return (ch == 0) ? 16 : 20;
  endfunction

  function automatic int err_pos(int ch);
    return 16 + ch;
  endfunction
endpackage

// File: rtl/sd_dma_regs.sv
module sd_dma_regs
  import sd_dma_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              start_o,
  output logic              ch_sel_o,
  output logic              inc_o,
  output logic [REG_W-1:0]  buf_addr_o,
  output logic [CNT_W-1:0]  len_o,
  output logic [NUM_CH-1:0] ch_rst_no
);
  logic [1:0] bw_q;

  assign start_o = we_i && (addr_i == OFF_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_sel_o   <= 1'b0;
      inc_o      <= 1'b0;
      bw_q       <= 2'b00;
      buf_addr_o <= '0;
      len_o      <= '0;
      ch_rst_no  <= '1;
    end else if (we_i) begin
      case (addr_i)
        OFF_MODE: begin
          ch_sel_o <= wdata_i[MODE_CH_BIT];
          inc_o    <= wdata_i[MODE_INC_BIT];
          bw_q     <= wdata_i[5:4];
        end
        OFF_CHRST: ch_rst_no  <= wdata_i[CHRST_LSB +: NUM_CH];
        OFF_BUF:   buf_addr_o <= wdata_i;
        OFF_LEN:   len_o      <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_MODE: begin
        rdata_o[MODE_CH_BIT]  = ch_sel_o;
        rdata_o[MODE_INC_BIT] = inc_o;
        rdata_o[5:4]          = bw_q;
      end
      OFF_CHRST: rdata_o[CHRST_LSB +: NUM_CH] = ch_rst_no;
      OFF_BUF:   rdata_o = buf_addr_o;
      OFF_LEN:   rdata_o[CNT_W-1:0] = len_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/sd_dma_status.sv
module sd_dma_status
  import sd_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic [NUM_CH-1:0] ch_rst_ni,
  input  logic [NUM_CH-1:0] done_set_i,
  input  logic [NUM_CH-1:0] err_set_i,
  output logic              irq_o
);
  logic [REG_W-1:0]  mask1_q, mask2_q, stat1_v, stat2_v;
  logic [NUM_CH-1:0] end_v, err_v;
  logic wr1, wr2;

  assign wr1 = we_i && (addr_i == OFF_STAT1);
  assign wr2 = we_i && (addr_i == OFF_STAT2);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam int EB = end_pos(i);
    localparam int ER = err_pos(i);
    logic end_r, err_r;

    // channel reset wins, then hardware set, then write-zero clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        end_r <= 1'b0;
        err_r <= 1'b0;
      end else if (!ch_rst_ni[i]) begin
        end_r <= 1'b0;
        err_r <= 1'b0;
      end else begin
        if (done_set_i[i])  end_r <= 1'b1;
        else if (wr1)       end_r <= end_r & wdata_i[EB];
        if (err_set_i[i])   err_r <= 1'b1;
        else if (wr2)       err_r <= err_r & wdata_i[ER];
      end
    end
    assign end_v[i] = end_r;
    assign err_v[i] = err_r;

    assert_w1_keep_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr1 && wdata_i[EB] && end_r && ch_rst_ni[i]) |=> end_r);
    assert_w1_keep_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr2 && wdata_i[ER] && err_r && ch_rst_ni[i]) |=> err_r);
    assert_rst_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_rst_ni[i] |=> !end_r && !err_r);
  end

  always_comb begin
    stat1_v = '0;
    stat2_v = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      stat1_v[end_pos(i)] = end_v[i];
      stat2_v[err_pos(i)] = err_v[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask1_q <= '1;
      mask2_q <= '1;
    end else if (we_i) begin
      if (addr_i == OFF_MASK1) mask1_q <= wdata_i;
      if (addr_i == OFF_MASK2) mask2_q <= wdata_i;
    end
  end

  assign irq_o = |(stat1_v & ~mask1_q) | |(stat2_v & ~mask2_q);

  always_comb begin
    case (addr_i)
      OFF_STAT1: rdata_o = stat1_v;
      OFF_MASK1: rdata_o = mask1_q;
      OFF_STAT2: rdata_o = stat2_v;
      OFF_MASK2: rdata_o = mask2_q;
      default:   rdata_o = '0;
    endcase
  end

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask1_q && &mask2_q) |-> !irq_o);
endmodule

// File: rtl/sd_dma_xfer.sv
module sd_dma_xfer
  import sd_dma_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ALIGN_BYTES = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              ch_sel_i,
  input  logic              inc_i,
  input  logic [REG_W-1:0]  buf_addr_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [NUM_CH-1:0] ch_rst_ni,
  output logic [NUM_CH-1:0] done_set_o,
  output logic [NUM_CH-1:0] err_set_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [REG_W-1:0]  mem_addr_o,
  output logic [REG_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [REG_W-1:0]  mem_rdata_i,
  output logic              card_tx_valid_o,
  output logic [REG_W-1:0]  card_tx_data_o,
  input  logic              card_tx_ready_i,
  input  logic              card_rx_valid_i,
  input  logic [REG_W-1:0]  card_rx_data_i,
  output logic              card_rx_ready_o
);
  localparam int ALIGN_LSB  = $clog2(ALIGN_BYTES);
  localparam int BEAT_BYTES = REG_W / 8;

  xfer_state_e      state_q, state_d;
  logic             ch_q, inc_q;
  logic [REG_W-1:0] cur_q, data_q;
  logic [CNT_W-1:0] remain_q;
  logic             abort, last, unaligned, beat_done;
  logic [REG_W-1:0] step;

  assign abort     = (state_q != ST_IDLE) && !ch_rst_ni[ch_q];
  assign last      = (remain_q == CNT_W'(1));
  assign unaligned = |buf_addr_i[ALIGN_LSB-1:0];
  assign step      = inc_q ? REG_W'(BEAT_BYTES) : '0;
  assign beat_done = ((state_q == ST_CARD_OUT) && card_tx_ready_i) ||
                     ((state_q == ST_MEM_WR) && mem_ack_i && !mem_err_i);

  always_comb begin
    state_d    = state_q;
    done_set_o = '0;
    err_set_o  = '0;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:
          if (start_i && ch_rst_ni[ch_sel_i]) begin
            if (unaligned)          err_set_o[ch_sel_i]  = 1'b1;
            else if (len_i == '0)   done_set_o[ch_sel_i] = 1'b1;
            else state_d = ch_sel_i ? ST_CARD_IN : ST_MEM_RD;
          end
        ST_MEM_RD:
          if (mem_ack_i) begin
            if (mem_err_i) begin
              err_set_o[ch_q] = 1'b1;
              state_d = ST_IDLE;
            end else state_d = ST_CARD_OUT;
          end
        ST_CARD_OUT:
          if (card_tx_ready_i) begin
            if (last) begin
              done_set_o[ch_q] = 1'b1;
              state_d = ST_IDLE;
            end else state_d = ST_MEM_RD;
          end
        ST_CARD_IN:
          if (card_rx_valid_i) state_d = ST_MEM_WR;
        ST_MEM_WR:
          if (mem_ack_i) begin
            if (mem_err_i) begin
              err_set_o[ch_q] = 1'b1;
              state_d = ST_IDLE;
            end else if (last) begin
              done_set_o[ch_q] = 1'b1;
              state_d = ST_IDLE;
            end else state_d = ST_CARD_IN;
          end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ch_q     <= 1'b0;
      inc_q    <= 1'b0;
      cur_q    <= '0;
      data_q   <= '0;
      remain_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && state_d != ST_IDLE) begin
        ch_q     <= ch_sel_i;
        inc_q    <= inc_i;
        cur_q    <= buf_addr_i;
        remain_q <= len_i;
      end
      if (!abort) begin
        if (state_q == ST_MEM_RD && mem_ack_i) data_q <= mem_rdata_i;
        if (state_q == ST_CARD_IN && card_rx_valid_i) data_q <= card_rx_data_i;
        if (beat_done && !last) begin
          remain_q <= remain_q - CNT_W'(1);
          cur_q    <= cur_q + step;
        end
      end
    end
  end

  assign mem_req_o       = (state_q == ST_MEM_RD) || (state_q == ST_MEM_WR);
  assign mem_we_o        = (state_q == ST_MEM_WR);
  assign mem_addr_o      = cur_q;
  assign mem_wdata_o     = data_q;
  assign card_tx_valid_o = (state_q == ST_CARD_OUT);
  assign card_tx_data_o  = data_q;
  assign card_rx_ready_o = (state_q == ST_CARD_IN);

  assert_one_side_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_req_o, card_tx_valid_o, card_rx_ready_o}));
  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && ch_rst_ni[ch_q]) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  assert_tx_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (card_tx_valid_o && !card_tx_ready_i && ch_rst_ni[ch_q]) |=>
      (card_tx_valid_o && $stable(card_tx_data_o)));
  assert_abort_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o || card_tx_valid_o || card_rx_ready_o) && !ch_rst_ni[ch_q] |=>
      !(mem_req_o || card_tx_valid_o || card_rx_ready_o));
  assert_end_xor_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(done_set_o & err_set_o)));
endmodule

// File: rtl/sd_dma_engine.sv
module sd_dma_engine
  import sd_dma_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ALIGN_BYTES = 128
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [REG_AW-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]    reg_wdata_i,
  output logic [REG_W-1:0]    reg_rdata_o,
  output logic                irq_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [REG_W-1:0]    mem_addr_o,
  output logic [REG_W-1:0]    mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic                mem_err_i,
  input  logic [REG_W-1:0]    mem_rdata_i,
  output logic                card_tx_valid_o,
  output logic [REG_W-1:0]    card_tx_data_o,
  input  logic                card_tx_ready_i,
  input  logic                card_rx_valid_i,
  input  logic [REG_W-1:0]    card_rx_data_i,
  output logic                card_rx_ready_o
);
  logic              start, ch_sel, inc;
  logic [REG_W-1:0]  buf_addr, cfg_rdata, stat_rdata;
  logic [CNT_W-1:0]  len;
  logic [NUM_CH-1:0] ch_rst_n, done_set, err_set;

  sd_dma_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(cfg_rdata),
    .start_o(start), .ch_sel_o(ch_sel), .inc_o(inc),
    .buf_addr_o(buf_addr), .len_o(len), .ch_rst_no(ch_rst_n)
  );

  sd_dma_status u_status (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(stat_rdata),
    .ch_rst_ni(ch_rst_n), .done_set_i(done_set), .err_set_i(err_set), .irq_o
  );

  sd_dma_xfer #(.CNT_W(CNT_W), .ALIGN_BYTES(ALIGN_BYTES)) u_xfer (
    .clk_i, .rst_ni,
    .start_i(start), .ch_sel_i(ch_sel), .inc_i(inc), .buf_addr_i(buf_addr), .len_i(len),
    .ch_rst_ni(ch_rst_n), .done_set_o(done_set), .err_set_o(err_set),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_err_i, .mem_rdata_i,
    .card_tx_valid_o, .card_tx_data_o, .card_tx_ready_i,
    .card_rx_valid_i, .card_rx_data_i, .card_rx_ready_o
  );

  assign reg_rdata_o = cfg_rdata | stat_rdata;
endmodule

// File: tb/sd_dma_engine_bench.sv
module sd_dma_engine_bench;
  localparam logic [11:0] A_MODE = 12'h820, A_CTRL = 12'h828, A_RST = 12'h830,
                          A_ST1 = 12'h840, A_MK1 = 12'h848, A_ST2 = 12'h850,
                          A_MK2 = 12'h858, A_BUF = 12'h880, A_LEN = 12'h888;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready;
  logic [31:0] tx_data, rx_data = '0;

  int checks = 0, failures = 0;
  int ack_cnt = 0, req_cycles = 0;
  logic [7:0] lf = 8'h5B;
  bit tx_en = 1'b1;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] exp_addr[$], exp_tx[$], exp_wd[$], rx_src[$];

  always #2 clk = ~clk;

  sd_dma_engine u_sd_dma_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_err_i(mem_err), .mem_rdata_i(mem_rdata),
    .card_tx_valid_o(tx_valid), .card_tx_data_o(tx_data), .card_tx_ready_i(tx_ready),
    .card_rx_valid_i(rx_valid), .card_rx_data_i(rx_data), .card_rx_ready_o(rx_ready)
  );

  function automatic logic [31:0] mem_val(logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h0101};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory, card and per-clock comparison model
  always @(negedge clk) begin
    if (rst_n) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (mem_req) req_cycles++;
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_req && lf[0]) begin
        mem_ack = 1'b1;
        ack_cnt++;
        if (exp_addr.size() == 0) check("R5 unexpected memory beat", mem_addr, 32'hDEAD_DEAD);
        else check("R4 memory address", mem_addr, exp_addr.pop_front());
        if (mem_we) begin
          if (exp_wd.size() == 0) check("R3 unexpected write", mem_wdata, 32'hDEAD_DEAD);
          else check("R3 memory write data", mem_wdata, exp_wd.pop_front());
        end else mem_rdata = mem_val(mem_addr);
        if (mem_addr == err_addr) mem_err = 1'b1;
      end
      tx_ready = tx_en && lf[1];
      if (tx_valid && tx_ready) begin
        if (exp_tx.size() == 0) check("R2 unexpected card word", tx_data, 32'hDEAD_DEAD);
        else check("R2 card word", tx_data, exp_tx.pop_front());
      end
      rx_valid = (rx_src.size() != 0) && lf[2];
      rx_data  = (rx_src.size() != 0) ? rx_src[0] : 32'h0;
      if (rx_valid && rx_ready) exp_wd.push_back(rx_src.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic run(input bit ch, input bit inc, input logic [31:0] a, input logic [31:0] n);
    wr(A_MODE, (32'(ch) << 16) | 32'h30 | 32'(inc));
    wr(A_BUF, a);
    wr(A_LEN, n);
    wr(A_CTRL, 32'h1);
  endtask

  task automatic wait_done();
    while (exp_addr.size() != 0 || exp_tx.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ST1, v); check("R1 end status", v, 32'h0);
    rd(A_ST2, v); check("R1 error status", v, 32'h0);
    rd(A_MK1, v); check("R1 mask1", v, 32'hFFFF_FFFF);
    rd(A_MK2, v); check("R1 mask2", v, 32'hFFFF_FFFF);
    rd(A_RST, v); check("R1 channel reset", v, 32'h300);
    rd(A_MODE, v); check("R1 mode", v, 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 no request", 32'(req_cycles), 32'h0);

    // R13 mode readback
    wr(A_MODE, 32'hFFFF_FFFF);
    rd(A_MODE, v); check("R13 mode fields", v, 32'h0001_0031);

    // R2/R4 channel 0 incrementing
    for (int i = 0; i < 4; i++) begin
      exp_addr.push_back(32'h1000 + 32'(4 * i));
      exp_tx.push_back(mem_val(32'h1000 + 32'(4 * i)));
    end
    run(1'b0, 1'b1, 32'h1000, 4);
    wait_done();
    rd(A_ST1, v); check("R2 end bit ch0", v, 32'h0001_0000);
    check("R9 masked irq", 32'(irq), 32'h0);
    wr(A_MK1, ~32'h0001_0000);
    #1 check("R9 unmasked end0 irq", 32'(irq), 32'h1);
    wr(A_MK1, ~32'h0010_0000);
    #1 check("R9 other mask bit", 32'(irq), 32'h0);
    wr(A_MK1, 32'hFFFF_FFFF);
    wr(A_ST1, 32'hFFFF_FFFF);
    rd(A_ST1, v); check("R8 write one keeps", v, 32'h0001_0000);
    wr(A_ST1, 32'h0);
    rd(A_ST1, v); check("R8 write zero clears", v, 32'h0);

    // R3/R4 channel 1 fixed address
    for (int i = 0; i < 3; i++) begin
      rx_src.push_back(32'hC0DE_0000 + 32'(i * 17));
      exp_addr.push_back(32'h2080);
    end
    run(1'b1, 1'b0, 32'h2080, 3);
    wait_done();
    rd(A_ST1, v); check("R3 end bit ch1", v, 32'h0010_0000);
    check("R3 all card words consumed", 32'(rx_src.size() + exp_wd.size()), 32'h0);
    wr(A_ST1, 32'h0);

    // R6 unaligned start
    base = req_cycles;
    run(1'b0, 1'b1, 32'h2004, 2);
    repeat (5) @(negedge clk);
    rd(A_ST2, v); check("R6 error ch0", v, 32'h0001_0000);
    run(1'b1, 1'b1, 32'h2040, 2);
    repeat (5) @(negedge clk);
    rd(A_ST2, v); check("R6 error ch1", v, 32'h0003_0000);
    rd(A_ST1, v); check("R6 no end bit", v, 32'h0);
    check("R6 no memory request", 32'(req_cycles - base), 32'h0);
    wr(A_MK2, ~32'h0002_0000);
    #1 check("R9 error irq", 32'(irq), 32'h1);
    wr(A_MK2, 32'hFFFF_FFFF);
    wr(A_ST2, ~32'h0002_0000);
    rd(A_ST2, v); check("R8 selective clear", v, 32'h0001_0000);
    wr(A_ST2, 32'h0);

    // R7 memory error mid-transfer
    base = ack_cnt;
    err_addr = 32'h3008;
    for (int i = 0; i < 3; i++) exp_addr.push_back(32'h3000 + 32'(4 * i));
    for (int i = 0; i < 2; i++) exp_tx.push_back(mem_val(32'h3000 + 32'(4 * i)));
    run(1'b0, 1'b1, 32'h3000, 5);
    wait_done();
    repeat (10) @(negedge clk);
    err_addr = 32'hFFFF_FFFF;
    rd(A_ST2, v); check("R7 error bit", v, 32'h0001_0000);
    rd(A_ST1, v); check("R7 no end bit", v, 32'h0);
    check("R7 beats before stop", 32'(ack_cnt - base), 32'h3);

    // R11 zero length
    base = req_cycles;
    run(1'b1, 1'b1, 32'h3100, 0);
    repeat (5) @(negedge clk);
    rd(A_ST1, v); check("R11 end bit", v, 32'h0010_0000);
    check("R11 no memory request", 32'(req_cycles - base), 32'h0);
    wr(A_ST1, 32'h0);

    // R5/R12 second start while busy
    base = ack_cnt;
    tx_en = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_addr.push_back(32'h4000 + 32'(4 * i));
      exp_tx.push_back(mem_val(32'h4000 + 32'(4 * i)));
    end
    run(1'b0, 1'b1, 32'h4000, 2);
    repeat (12) @(negedge clk);
    check("R12 tx valid held", 32'(tx_valid), 32'h1);
    check("R12 tx data", tx_data, mem_val(32'h4000));
    wr(A_BUF, 32'h5000);
    wr(A_CTRL, 32'h1);
    repeat (4) @(negedge clk);
    check("R12 tx data stable", tx_data, mem_val(32'h4000));
    tx_en = 1'b1;
    wait_done();
    repeat (10) @(negedge clk);
    check("R5 beats of first start only", 32'(ack_cnt - base), 32'h2);
    rd(A_ST1, v); check("R5 end bit", v, 32'h0001_0000);
    wr(A_ST1, 32'h0);

    // R10 channel reset during a stalled transfer
    tx_en = 1'b0;
    exp_addr.push_back(32'h6000);
    exp_tx.push_back(mem_val(32'h6000));
    run(1'b0, 1'b1, 32'h6000, 100);
    repeat (12) @(negedge clk);
    check("R10 stalled before reset", 32'(tx_valid), 32'h1);
    wr(A_ST2, 32'h0);
    wr(A_RST, 32'h200);
    repeat (2) @(negedge clk);
    check("R10 tx dropped", 32'(tx_valid), 32'h0);
    check("R10 no request", 32'(mem_req), 32'h0);
    rd(A_RST, v); check("R10 reset readback", v, 32'h200);
    exp_tx.delete();
    exp_addr.delete();
    tx_en = 1'b1;
    base = req_cycles;
    wr(A_BUF, 32'h6100);
    wr(A_LEN, 32'h1);
    wr(A_CTRL, 32'h1);
    repeat (6) @(negedge clk);
    check("R10 start ignored in reset", 32'(req_cycles - base), 32'h0);
    rd(A_ST1, v); check("R10 no end in reset", v, 32'h0);
    wr(A_RST, 32'h300);
    exp_addr.push_back(32'h7000);
    exp_tx.push_back(mem_val(32'h7000));
    wr(A_BUF, 32'h7000);
    wr(A_CTRL, 32'h1);
    wait_done();
    rd(A_ST1, v); check("R10 released channel works", v, 32'h0001_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule